// File: doc/BRIEF.md
# Cross-Domain Interrupt Aggregator

This block gathers a wide bundle of interrupt request lines coming from the main application power domain and folds them into two combined requests for a small always-on microcontroller. Each combined request has its own 64-bit source mask, split across two 32-bit words. It also has its own pair of 32-bit status words, which show the sources that are active and enabled for that output.

A global enable gates both requests. A separate enable for each output then decides whether its combined request reaches the controller. The two requests leave the block on active-low lines that feed the controller's two external interrupt inputs. These lines may be wired together with other always-on sources. A small word-addressed register bus sets up the masks and enables and reads back status.

Source lines are asynchronous to the always-on clock. They pass through two synchroniser flops before masking, and the output lines are registered.

Top module: `irq_fold`

## Requirements
- R1: After reset, every mask word and the control register read 0, and both `irq_n` lines are high.
- R2: Mask words are read/write at byte addresses 0x04 (output 0, sources 31..0), 0x08 (output 0, sources 63..32), 0x0C (output 1, sources 31..0) and 0x10 (output 1, sources 63..32). Bit i of a word maps to source i within that word's range.
- R3: `irq_n[k]` is driven low exactly when the global enable is set, the enable for output k is set, and at least one synchronised source is both active and enabled in mask k.
- R4: Control register bit 0 at address 0x00 is the global enable. While it is 0, both `irq_n` lines stay high whatever the sources and masks are.
- R5: Control bits 1 and 2 enable output 0 and output 1 respectively. Clearing one forces only its own line high.
- R6: The status words at 0x14/0x18 (output 0, low/high) and 0x1C/0x20 (output 1, low/high) read the synchronised sources ANDed with the mask. They are not sticky, and writes to them have no effect.
- R7: A source change appears in status after two rising clock edges and on `irq_n` after three.
- R8: Reads of any address not listed above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 64 | Raw interrupt levels from the application domain |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_n | output | 2 | Active-low combined requests to the two external interrupt inputs |

## Verification
The bench targets the edges of the source range, bits 0, 31, 32 and 63, in both masks. A design that swapped the mask words or their halves would assert the wrong line, or report status in the wrong word. It also checks that the global bit and each output enable block only the line they own; a crossed enable would silence or raise the neighbouring line. Cycle-exact sampling catches a synchroniser one stage short or long. Writes to status addresses followed by readback expose status bits that latch or accept writes.

// File: rtl/irq_fold.sv
module irq_fold #(
  parameter int N_SRC = 64,
  parameter int WORD  = 32,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_irq,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WORD-1:0]  bus_wdata,
  output logic [WORD-1:0]  bus_rdata,
  output logic [1:0]       irq_n
);
  localparam int NOUT      = 2;
  localparam int NW        = N_SRC / WORD;
  localparam int MASK_BASE = 1;
  localparam int STAT_BASE = MASK_BASE + NOUT * NW;

  logic [N_SRC-1:0] mask_q [NOUT];
  logic [N_SRC-1:0] stat   [NOUT];
  logic [N_SRC-1:0] sync1_q, sync2_q;
  logic             glb_q;
  logic [NOUT-1:0]  line_en_q;
  logic [NOUT-1:0]  irq_n_q;
  int               widx;

  assign widx  = int'(bus_addr[AW-1:2]);
  assign irq_n = irq_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= src_irq;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q     <= 1'b0;
      line_en_q <= '0;
    end else if (bus_we && widx == 0) begin
      glb_q     <= bus_wdata[0];
      line_en_q <= bus_wdata[NOUT:1];
    end
  end

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assign stat[k] = sync2_q & mask_q[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[k]  <= '0;
        irq_n_q[k] <= 1'b1;
      end else begin
        for (int w = 0; w < NW; w++)
          if (bus_we && widx == MASK_BASE + k * NW + w)
            mask_q[k][w*WORD +: WORD] <= bus_wdata;
        irq_n_q[k] <= ~(glb_q & line_en_q[k] & (|stat[k]));
      end
    end

    AST_LINE_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n_q[k] |-> $past(|stat[k]));                                  // R3
    AST_LINE_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_en_q[k] |=> irq_n_q[k]);                                     // R5
  end

  always_comb begin
    bus_rdata = '0;
    if (widx == 0) begin
      bus_rdata[0]      = glb_q;
      bus_rdata[NOUT:1] = line_en_q;
    end
    for (int k = 0; k < NOUT; k++)
      for (int w = 0; w < NW; w++) begin
        if (widx == MASK_BASE + k * NW + w) bus_rdata = mask_q[k][w*WORD +: WORD];
        if (widx == STAT_BASE + k * NW + w) bus_rdata = stat[k][w*WORD +: WORD];
      end
  end

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_q |=> irq_n_q == '1);                                           // R4
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && widx == MASK_BASE) |=> mask_q[0][WORD-1:0] == $past(bus_wdata)); // R2
endmodule

// File: tb/tb_irq_fold.sv
module tb_irq_fold;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_irq = '0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_n;

  int total = 0, bad = 0;
  logic [63:0] m_mask [2];
  logic [2:0]  m_ctrl;

  irq_fold dut (.*);

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    if (a == 6'h00) m_ctrl = d[2:0];
    if (a >= 6'h04 && a <= 6'h10) begin
      if (a[3:2] == 2'd1) m_mask[0][31:0]  = d;
      if (a[3:2] == 2'd2) m_mask[0][63:32] = d;
      if (a[3:2] == 2'd3) m_mask[1][31:0]  = d;
      if (a == 6'h10)     m_mask[1][63:32] = d;
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [1:0] exp_n(input logic [63:0] s);
    logic [1:0] r;
    for (int k = 0; k < 2; k++)
      r[k] = ~(m_ctrl[0] & m_ctrl[k+1] & (|(s & m_mask[k])));
    return r;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [63:0] st;
    chk({30'b0, irq_n}, {30'b0, exp_n(src_irq)}, {tag, " R3 line"});
    for (int k = 0; k < 2; k++) begin
      st = src_irq & m_mask[k];
      rd(6'h14 + 6'(k*8), d); chk(d, st[31:0],  {tag, " R6 status lo"});
      rd(6'h18 + 6'(k*8), d); chk(d, st[63:32], {tag, " R6 status hi"});
    end
  endtask

  initial begin
    logic [31:0] d;
    logic [1:0]  prev;
    void'($urandom(32'd4242));
    m_mask[0] = '0; m_mask[1] = '0; m_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({30'b0, irq_n}, 32'h3, "R1 lines idle");
    for (int a = 0; a < 9; a++) begin
      rd(6'(a*4), d); chk(d, 32'h0, "R1 reg zero");
    end

    src_irq = 64'hFFFF_FFFF_FFFF_FFFF;
    wr(6'h04, 32'h8000_0001); wr(6'h08, 32'h8000_0001);
    wr(6'h0C, 32'h0000_0001); wr(6'h10, 32'h8000_0000);
    repeat (4) @(negedge clk);
    chk({30'b0, irq_n}, 32'h3, "R4 global off");
    wr(6'h00, 32'h6);
    repeat (4) @(negedge clk);
    chk({30'b0, irq_n}, 32'h3, "R4 global off with line enables");
    rd(6'h08, d); chk(d, 32'h8000_0001, "R2 mask0 hi readback");
    rd(6'h10, d); chk(d, 32'h8000_0000, "R2 mask1 hi readback");

    wr(6'h00, 32'h3);
    repeat (4) @(negedge clk);
    chk({30'b0, irq_n}, 32'h2, "R5 only line0");
    wr(6'h00, 32'h5);
    repeat (4) @(negedge clk);
    chk({30'b0, irq_n}, 32'h1, "R5 only line1");
    wr(6'h00, 32'h7);

    src_irq = 64'h8000_0000_0000_0000;
    repeat (4) @(negedge clk);
    check_all("bit63");
    src_irq = 64'h0000_0001_0000_0000;
    repeat (4) @(negedge clk);
    check_all("bit32");
    src_irq = 64'h0000_0000_8000_0000;
    repeat (4) @(negedge clk);
    check_all("bit31");

    wr(6'h14, 32'hFFFF_FFFF); wr(6'h20, 32'hFFFF_FFFF);
    src_irq = '0;
    repeat (4) @(negedge clk);
    check_all("R6 status write ignored, not sticky");
    rd(6'h24, d); chk(d, 32'h0, "R8 unmapped 0x24");
    rd(6'h3C, d); chk(d, 32'h0, "R8 unmapped 0x3C");

    prev = irq_n;
    src_irq = 64'h1;
    @(negedge clk);
    rd(6'h14, d); chk(d, 32'h0, "R7 status after one edge");
    @(negedge clk);
    rd(6'h14, d); chk(d, 32'h1, "R7 status after two edges");
    chk({30'b0, irq_n}, {30'b0, prev}, "R7 line after two edges");
    @(negedge clk);
    chk({30'b0, irq_n}, 32'h0, "R7 line after three edges");

    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 1)) wr(6'(4 * $urandom_range(1, 4)), $urandom & $urandom);
      if ($urandom_range(0, 3) == 0) wr(6'h00, {29'b0, 3'($urandom)});
      src_irq = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
      repeat (4) @(negedge clk);
      check_all("rand");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule